// File: doc/BRIEF.md
# Two-Stage Half-Band Interpolator (2x / 4x)

This block raises the sample rate of a stream of 16-bit real samples by two or by four. It holds two identical half-band stages. Each stage inserts a zero between successive input samples and runs the doubled-rate stream through a 47-tap symmetric low-pass filter, so every input sample leaves the stage as two output samples. For 2x operation only the first stage runs; for 4x the second stage takes the first stage's output. The transition band of each stage lies between 0.4 and 0.6 of that stage's input rate.

Each stage can swap its low-pass response for the mirrored high-pass response, which moves the passband up by half of that stage's output rate. An input format stage takes samples as two's complement or as offset binary. The block runs on one clock at the final output rate. The upstream source presents a sample with `inValid` no more often than once every two clocks (2x) or once every four clocks (4x). The block then produces one output sample per clock. Configuration inputs are static and may change only while reset is held.

Top module: `hb_interp`

## Requirements
- R1: While `rst` is high and on the first clock after it falls, `outValid` is 0 and `outData` is 0. Reset also clears every stored sample in both stages.
- R2: With `cfgQuad`=0, an input accepted in clock cycle c gives exactly two outputs, valid in cycles c+2 and c+3.
- R3: With `cfgQuad`=1, an input accepted in cycle c gives exactly four outputs, valid in cycles c+4 through c+7. The second stage loads each first-stage output in the cycle that output becomes valid.
- R4: Each stage's impulse response spans 47 output samples. The samples at odd distance d=2k+1 from the centre carry side coefficients in Q15. For k=0..11 these are 20720, -6500, 3500, -2200, 1450, -950, 600, -370, 215, -115, 52, -18. Both stages use the same set. Samples at even nonzero distance are zero.
- R5: The centre tap has gain exactly one. For each input, a stage's first output copies the input sample held 12 inputs earlier, without rounding.
- R6: The side coefficients sum to 0.5 in Q15 on each side, so a constant input A gives A on every output once the delay lines have filled (DC gain one).
- R7: Side-phase sums are kept at full precision, then rounded by adding 2^14 and shifting right arithmetically by 15.
- R8: Rounded side-phase results above 32767 or below -32768 saturate to those limits.
- R9: When `cfgHp[0]` (first stage) or `cfgHp[1]` (second stage) is 1, that stage's side coefficients are negated before rounding, which gives the high-pass response. The centre tap is unchanged.
- R10: With `cfgTwos`=1, `inData` is read as two's complement. With `cfgTwos`=0 it is read as offset binary, and the MSB is inverted before filtering.
- R11: With `cfgQuad`=0 the second stage never emits a sample, and `cfgHp[1]` has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at the output sample rate |
| rst | input | 1 | Synchronous active-high reset |
| cfgQuad | input | 1 | 1 selects 4x (two stages), 0 selects 2x (first stage only) |
| cfgTwos | input | 1 | 1 = two's complement input, 0 = offset binary input |
| cfgHp | input | 2 | High-pass select per stage: bit 0 first stage, bit 1 second stage |
| inValid | input | 1 | Input sample strobe |
| inData | input | 16 | Input sample |
| outValid | output | 1 | Output sample strobe |
| outData | output | 16 | Output sample, two's complement |

## Verification
The bench builds the block with its default parameters: 16-bit samples, 12 symmetric side pairs, 15 fractional coefficient bits and two stages. With these values a 32-sample input run drives the full 47-tap impulse response out of both stages, and in 4x mode it also fills the cascade with settled DC. The side-phase gain of about 2.24 means that a 24-sample burst shaped to the coefficient signs drives the rounding stage into both saturation limits. Each output stream is compared with a direct-form convolution of the zero-stuffed input. This model is a different formulation from the polyphase structure in the design.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  localparam int SAMPLE_W  = 16;
  localparam int COEF_W    = 16;
  localparam int N_SIDE    = 12;
  localparam int FRAC_BITS = 15;
  localparam int N_STAGE   = 2;

  // Strobes from the control to the datapath, one bit per stage.
  typedef struct packed {
    logic [N_STAGE-1:0] ld;   // shift a new sample into the stage
    logic [N_STAGE-1:0] emC;  // emit the centre-phase sample
    logic [N_STAGE-1:0] emS;  // emit the side-phase sample
  } strobe_t;

  // Side coefficient for distance 2k+1 from the centre, Q15.
  function automatic logic signed [COEF_W-1:0] sideCoef(input int k);
    case (k)
      0:       return 16'sd20720;
      1:       return -16'sd6500;
      2:       return 16'sd3500;
      3:       return -16'sd2200;
      4:       return 16'sd1450;
      5:       return -16'sd950;
      6:       return 16'sd600;
      7:       return -16'sd370;
      8:       return 16'sd215;
      9:       return -16'sd115;
      10:      return 16'sd52;
      11:      return -16'sd18;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/hbi_stage.sv
module hbi_stage
  import hbi_pkg::*;
#(
  parameter int SW = SAMPLE_W,
  parameter int NS = N_SIDE,
  parameter int FB = FRAC_BITS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ld,
  input  logic                 emC,
  input  logic                 emS,
  input  logic                 hp,
  input  logic signed [SW-1:0] inSample,
  output logic                 outValid,
  output logic signed [SW-1:0] outSample
);
  localparam int NTAP = 2 * NS;
  localparam int PW   = SW + 1;
  localparam int ACCW = PW + COEF_W + $clog2(NS);
  typedef logic signed [ACCW-1:0] acc_t;
  localparam logic signed [SW-1:0] OUT_MAX = {1'b0, {(SW-1){1'b1}}};
  localparam logic signed [SW-1:0] OUT_MIN = {1'b1, {(SW-1){1'b0}}};
  localparam acc_t MAXV = acc_t'(OUT_MAX);
  localparam acc_t MINV = acc_t'(OUT_MIN);
  localparam acc_t HALF = acc_t'(1) <<< (FB - 1);

  logic signed [SW-1:0] tap [NTAP];
  acc_t prod [NS];
  acc_t accSum, accSigned, roundSh;
  logic signed [SW-1:0] satOut;

  // Delay line: tap[0] holds the newest sample.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NTAP; i++) tap[i] <= '0;
    end else if (ld) begin
      tap[0] <= inSample;
      for (int i = 1; i < NTAP; i++) tap[i] <= tap[i-1];
    end
  end

  // Pre-add symmetric taps, then one multiplier per pair.
  for (genvar k = 0; k < NS; k++) begin : gPair
    logic signed [PW-1:0] pairSum;
    assign pairSum = PW'(tap[NS-1-k]) + PW'(tap[NS+k]);
    assign prod[k] = acc_t'(pairSum) * acc_t'(sideCoef(k));
  end

  always_comb begin
    accSum = '0;
    for (int k = 0; k < NS; k++) accSum = accSum + prod[k];
    accSigned = hp ? -accSum : accSum;
    roundSh   = (accSigned + HALF) >>> FB;
    if (roundSh > MAXV)      satOut = OUT_MAX;
    else if (roundSh < MINV) satOut = OUT_MIN;
    else                     satOut = roundSh[SW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid  <= 1'b0;
      outSample <= '0;
    end else begin
      outValid <= emC | emS;
      if (emC)      outSample <= tap[NS];
      else if (emS) outSample <= satOut;
    end
  end

  // R8: oversized side results clamp to the limits
  a_r8_clamp_hi: assert property (@(posedge clk) disable iff (rst)
    (emS && !emC && roundSh > MAXV) |=> (outSample == OUT_MAX));
  a_r8_clamp_lo: assert property (@(posedge clk) disable iff (rst)
    (emS && !emC && roundSh < MINV) |=> (outSample == OUT_MIN));
endmodule

// File: rtl/hbi_ctrl.sv
module hbi_ctrl
  import hbi_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               cfgQuad,
  input  logic               inValid,
  input  logic [N_STAGE-1:0] stgValid,
  output strobe_t            st
);
  logic [1:0] ph;
  logic [1:0] lastPh;
  logic e1, e1d, e1dd;

  assign lastPh = cfgQuad ? 2'd3 : 2'd2;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph   <= '0;
      e1   <= 1'b0;
      e1d  <= 1'b0;
      e1dd <= 1'b0;
    end else begin
      if (inValid)           ph <= 2'd1;
      else if (ph == lastPh) ph <= 2'd0;
      else if (ph != 2'd0)   ph <= ph + 2'd1;
      e1   <= st.emC[0] | st.emS[0];
      e1d  <= e1;
      e1dd <= e1d;
    end
  end

  always_comb begin
    st        = '0;
    st.ld[0]  = inValid;
    st.emC[0] = (ph == 2'd1);
    st.emS[0] = (ph == lastPh);
    st.ld[1]  = cfgQuad & e1;
    st.emC[1] = cfgQuad & e1d;
    st.emS[1] = cfgQuad & e1dd;
  end

  // R3: second stage loads every first-stage output in 4x mode
  a_r3_stage2_feed: assert property (@(posedge clk) disable iff (rst)
    (cfgQuad && stgValid[0]) |-> st.ld[1]);
  // R11: second stage stays silent in 2x mode
  a_r11_stage2_idle: assert property (@(posedge clk) disable iff (rst)
    !cfgQuad |-> !stgValid[1]);
endmodule

// File: rtl/hbi_datapath.sv
module hbi_datapath
  import hbi_pkg::*;
#(
  parameter int SW   = SAMPLE_W,
  parameter int NSTG = N_STAGE
) (
  input  logic                 clk,
  input  logic                 rst,
  input  strobe_t              st,
  input  logic                 cfgTwos,
  input  logic                 cfgQuad,
  input  logic [NSTG-1:0]      cfgHp,
  input  logic signed [SW-1:0] inData,
  output logic                 outValid,
  output logic signed [SW-1:0] outData,
  output logic [NSTG-1:0]      stgValid
);
  logic signed [SW-1:0] inConv;
  logic signed [SW-1:0] stIn  [NSTG];
  logic signed [SW-1:0] stOut [NSTG];

  // Offset binary differs from two's complement only in the MSB.
  assign inConv = cfgTwos ? inData : {~inData[SW-1], inData[SW-2:0]};

  for (genvar g = 0; g < NSTG; g++) begin : gStage
    if (g == 0) begin : gFirst
      assign stIn[g] = inConv;
    end else begin : gNext
      assign stIn[g] = stOut[g-1];
    end
    hbi_stage #(.SW(SW)) uStage (
      .clk      (clk),
      .rst      (rst),
      .ld       (st.ld[g]),
      .emC      (st.emC[g]),
      .emS      (st.emS[g]),
      .hp       (cfgHp[g]),
      .inSample (stIn[g]),
      .outValid (stgValid[g]),
      .outSample(stOut[g])
    );
  end

  assign outValid = cfgQuad ? stgValid[NSTG-1] : stgValid[0];
  assign outData  = cfgQuad ? stOut[NSTG-1]    : stOut[0];
endmodule

// File: rtl/hb_interp.sv
module hb_interp
  import hbi_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfgQuad,
  input  logic                       cfgTwos,
  input  logic [N_STAGE-1:0]         cfgHp,
  input  logic                       inValid,
  input  logic signed [SAMPLE_W-1:0] inData,
  output logic                       outValid,
  output logic signed [SAMPLE_W-1:0] outData
);
  strobe_t            st;
  logic [N_STAGE-1:0] stgValid;

  hbi_ctrl uCtrl (
    .clk     (clk),
    .rst     (rst),
    .cfgQuad (cfgQuad),
    .inValid (inValid),
    .stgValid(stgValid),
    .st      (st)
  );

  hbi_datapath uDp (
    .clk     (clk),
    .rst     (rst),
    .st      (st),
    .cfgTwos (cfgTwos),
    .cfgQuad (cfgQuad),
    .cfgHp   (cfgHp),
    .inData  (inData),
    .outValid(outValid),
    .outData (outData),
    .stgValid(stgValid)
  );

  // R2: two outputs per input, two and three cycles later
  a_r2_two_outputs: assert property (@(posedge clk) disable iff (rst)
    (!cfgQuad && inValid) |-> ##2 outValid ##1 outValid);
  // R3: four outputs per input, four to seven cycles later
  a_r3_four_outputs: assert property (@(posedge clk) disable iff (rst)
    (cfgQuad && inValid) |-> ##4 outValid ##1 outValid ##1 outValid ##1 outValid);
endmodule

// File: tb/sim_hb_interp.sv
`timescale 1ns/1ps
module sim_hb_interp;
  localparam int NIN = 32;
  typedef int seq_t [128];
  typedef struct packed {
    logic              quad;
    logic              twos;
    logic [1:0]        hp;
    logic [2:0]        pat;   // 0 impulse, 1 constant, 2 sign burst, 3 pseudo-random
    logic signed [15:0] amp;
  } case_t;

  localparam int NCASE = 13;
  localparam case_t CASES [NCASE] = '{
    '{1'b0, 1'b1, 2'b00, 3'd0, 16'sd32767},   // R4 impulse 2x
    '{1'b1, 1'b1, 2'b00, 3'd0, 16'sd32767},   // R4 impulse 4x
    '{1'b0, 1'b1, 2'b00, 3'd1, 16'sd12345},   // R6 DC 2x
    '{1'b1, 1'b1, 2'b00, 3'd1, -16'sd20000},  // R6 DC 4x
    '{1'b0, 1'b1, 2'b01, 3'd0, 16'sd32767},   // R9 high-pass impulse 2x
    '{1'b1, 1'b1, 2'b10, 3'd3, 16'sd0},       // R9 second stage high-pass
    '{1'b1, 1'b1, 2'b11, 3'd3, 16'sd0},       // R9 both high-pass
    '{1'b0, 1'b1, 2'b00, 3'd2, 16'sd30000},   // R8 positive clamp
    '{1'b1, 1'b1, 2'b00, 3'd2, -16'sd30000},  // R8 negative clamp
    '{1'b0, 1'b0, 2'b00, 3'd3, 16'sd0},       // R10 offset binary 2x
    '{1'b1, 1'b0, 2'b00, 3'd1, 16'sd7000},    // R10 offset binary 4x
    '{1'b0, 1'b1, 2'b10, 3'd3, 16'sd0},       // R11 second-stage select ignored
    '{1'b0, 1'b1, 2'b00, 3'd0, 16'sd1001}     // R7 rounding of small products
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfgQuad = 1'b0;
  logic cfgTwos = 1'b1;
  logic [1:0] cfgHp = 2'b00;
  logic inValid = 1'b0;
  logic signed [15:0] inData = '0;
  logic outValid;
  logic signed [15:0] outData;

  int nChecks = 0;
  int nFails  = 0;
  bit capEn = 1'b0;
  int gotCnt = 0;
  int got [128];
  seq_t xs, s1, s2;

  always #4 clk = ~clk;

  hb_interp u0 (
    .clk(clk), .rst(rst), .cfgQuad(cfgQuad), .cfgTwos(cfgTwos), .cfgHp(cfgHp),
    .inValid(inValid), .inData(inData), .outValid(outValid), .outData(outData)
  );

  always @(negedge clk) begin
    if (capEn && outValid && gotCnt < 128) begin
      got[gotCnt] = int'(outData);
      gotCnt = gotCnt + 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp, input string what);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic string tagOf(input int idx);
    case (idx)
      0, 1, 12: return (idx == 12) ? "R7" : "R4";
      2, 3:     return "R6";
      4, 5, 6:  return "R9";
      7, 8:     return "R8";
      9, 10:    return "R10";
      default:  return "R11";
    endcase
  endfunction

  // Side coefficients in Q15 as stated in R4
  function automatic longint ctab(input int k);
    case (k)
      0: return 20720;  1: return -6500; 2: return 3500;  3: return -2200;
      4: return 1450;   5: return -950;  6: return 600;   7: return -370;
      8: return 215;    9: return -115;  10: return 52;   11: return -18;
      default: return 0;
    endcase
  endfunction

  function automatic longint hco(input int t, input bit hp);
    int d, ad;
    d = t - 23;
    if (d == 0) return 32768;
    if ((d % 2) == 0) return 0;
    ad = (d < 0) ? -d : d;
    return hp ? -ctab((ad - 1) / 2) : ctab((ad - 1) / 2);
  endfunction

  // Direct-form convolution over the zero-stuffed input
  task automatic modelStage(input seq_t src, input int n, input bit hp, output seq_t dst);
    for (int m = 0; m < 128; m++) dst[m] = 0;
    for (int m = 0; m < 2 * n; m++) begin
      longint acc = 0;
      for (int t = 0; t < 47; t++) begin
        int p = m - 1 - t;
        if (p >= 0 && (p % 2) == 0) acc += hco(t, hp) * longint'(src[p / 2]);
      end
      acc = (acc + 16384) >>> 15;
      if (acc > 32767) acc = 32767;
      if (acc < -32768) acc = -32768;
      dst[m] = int'(acc);
    end
  endtask

  function automatic int patVal(input logic [2:0] pat, input int amp, input int m);
    int r, k;
    case (pat)
      3'd0: return (m == 0) ? amp : 0;
      3'd1: return amp;
      3'd2: begin
        if (m >= 24) return 0;
        k = (m <= 11) ? (11 - m) : (m - 12);
        return ((k % 2) == 0) ? amp : -amp;
      end
      default: begin
        r = (m * 40503 + 12345) & 32'hFFFF;
        return (r >= 32768) ? r - 65536 : r;
      end
    endcase
  endfunction

  task automatic doReset(input logic q, input logic tw, input logic [1:0] hp);
    @(negedge clk);
    rst = 1'b1; inValid = 1'b0; inData = '0;
    cfgQuad = q; cfgTwos = tw; cfgHp = hp;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic runCase(input int idx);
    case_t c;
    int f, v;
    c = CASES[idx];
    f = c.quad ? 4 : 2;
    doReset(c.quad, c.twos, c.hp);
    gotCnt = 0;
    capEn = 1'b1;
    for (int i = 0; i < NIN; i++) begin
      v = patVal(c.pat, int'(c.amp), i);
      xs[i] = v;
      @(negedge clk);
      inValid = 1'b1;
      inData = c.twos ? 16'(v) : (16'(v) ^ 16'h8000);
      repeat (f - 1) begin
        @(negedge clk);
        inValid = 1'b0;
      end
    end
    @(negedge clk);
    inValid = 1'b0;
    repeat (20) @(negedge clk);
    capEn = 1'b0;
    modelStage(xs, NIN, c.hp[0], s1);
    if (c.quad) modelStage(s1, 2 * NIN, c.hp[1], s2);
    chk(c.quad ? "R3" : "R2", gotCnt, f * NIN, $sformatf("case %0d output count", idx));
    for (int i = 0; i < f * NIN && i < gotCnt; i++)
      chk(tagOf(idx), got[i], c.quad ? s2[i] : s1[i], $sformatf("case %0d sample %0d", idx, i));
    if (idx == 0) chk("R5", got[24], 32767, "centre tap copy");
    if (idx == 2 || idx == 3 || idx == 10)
      chk("R6", got[gotCnt - 1], int'(c.amp), "settled DC value");
  endtask

  task automatic latency(input logic q);
    int k, seen, first;
    doReset(q, 1'b1, 2'b00);
    @(negedge clk);
    inValid = 1'b1; inData = 16'sd100;
    first = -1; seen = 0;
    for (k = 1; k <= 12; k++) begin
      @(negedge clk);
      inValid = 1'b0;
      if (outValid) begin
        if (first < 0) first = k;
        seen++;
      end
    end
    chk(q ? "R3" : "R2", first, q ? 4 : 2, "first output delay");
    chk(q ? "R3" : "R2", seen, q ? 4 : 2, "outputs per input");
  endtask

  initial begin
    #1200000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", int'(outValid), 0, "valid in reset");
    chk("R1", int'(outData), 0, "data in reset");
    rst = 1'b0;
    @(negedge clk);
    chk("R1", int'(outValid), 0, "valid after reset");
    chk("R1", int'(outData), 0, "data after reset");
    latency(1'b0);
    latency(1'b1);
    for (int i = 0; i < NCASE; i++) runCase(i);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule